// File: doc/BRIEF.md
# Hardware Transaction Conflict Tracker

This unit sits next to a processor's small data cache and follows one hardware transaction for each of a few thread contexts. The core sends it one request per cycle: begin, commit, abort, transactional load or transactional store, tagged with a context number. Each line that a running transaction touches gets an entry in a shared line table. The entry carries a read mark, a write mark and, for stores, the speculative data. Other processors stay blind to that data until the owning transaction commits. After a commit the written lines are drained to the cache one per cycle.

Coherence snoops from other processors are compared with the line table. A remote write that hits a line in a transaction's read or write set aborts that transaction. A remote read that hits a line the transaction has written also aborts it. Accesses from two local contexts follow the same single-writer rule. An aborted transaction loses its table entries, so the values from before the transaction stay the valid ones, and the context is marked doomed. A doomed context that tries a commit, load or store gets a trap. The trap stays raised until the core acknowledges it. A per-context failure counter raises a hint to retry in software once a set number of consecutive aborts has been reached.

Top module: `htm_conflict_tracker`

## Requirements
- R1: After reset, every context is idle and not doomed, and `trap`, `sw_hint`, `ld_valid` and `wb_valid` are all low.
- R2: A begin request (`req_op` = 1) from an idle, non-doomed context raises its `in_tx` bit one cycle later. A begin from a doomed context has no effect.
- R3: Inside a transaction a load (`req_op` = 4) sets the read mark of its line and a store (`req_op` = 5) sets the write mark and records the data. One cycle after a load, `ld_valid` is high. `ld_fwd`/`ld_data` return the context's own speculative data when it has stored to that line, and `ld_fwd` is 0 otherwise.
- R4: Speculative store data never appears on the write-back port before commit. A commit (`req_op` = 2) from an active, non-doomed context drops `in_tx` and resets the context's failure count. Starting the cycle after the commit, the written lines leave on `wb_valid`/`wb_addr`/`wb_data` one per cycle in table-slot order, lowest slot first. Read-only lines are not written back.
- R5: A snoop write (`snp_write` = 1) to a line that a transaction has read or written aborts it. A snoop to a line that no transaction holds has no effect.
- R6: A snoop read (`snp_write` = 0) to a line that a transaction has written aborts it. A snoop read to a line that was only read has no effect.
- R7: A store by one context to a line held by another context aborts the other context. A load by one context of a line written by another context does the same.
- R8: On abort the context's `in_tx` falls and `doomed` rises in the same cycle. Its table entries are discarded: nothing of it is written back, and its slots are free again.
- R9: A commit, load or store from a doomed context sets that context's `trap` bit instead of executing. The trap stays high until `trap_ack` for that context, and the acknowledgment clears both `trap` and `doomed` one cycle later.
- R10: A load or store that needs a new slot while all NLINES slots are occupied aborts its own transaction.
- R11: `sw_hint` of a context is high once it has RETRY_LIMIT or more consecutive aborts, counting an explicit abort (`req_op` = 3), and stays low below that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request strobe |
| req_op | input | 3 | 1 begin, 2 commit, 3 abort, 4 load, 5 store |
| req_ctx | input | $clog2(NCTX) | Requesting context |
| req_addr | input | AW | Line address of a load or store |
| req_wdata | input | DW | Store data |
| trap_ack | input | NCTX | Per-context trap acknowledgment |
| snp_valid | input | 1 | Remote snoop strobe |
| snp_write | input | 1 | Snoop is a remote write (1) or read (0) |
| snp_addr | input | AW | Snooped line address |
| in_tx | output | NCTX | Context has an active transaction |
| doomed | output | NCTX | Context's transaction was aborted and not yet acknowledged |
| trap | output | NCTX | Trap raised for the context |
| sw_hint | output | NCTX | Advise the next attempt to run in software |
| ld_valid | output | 1 | A tracked load completed |
| ld_fwd | output | 1 | Load hit the context's own speculative data |
| ld_data | output | DW | Forwarded speculative data |
| wb_valid | output | 1 | Committed line leaving for the cache |
| wb_addr | output | AW | Address of the committed line |
| wb_data | output | DW | Data of the committed line |

## Verification
On every cycle the assertions check these rules: a trap rises only for a doomed context and holds until it is acknowledged; a context is never active and doomed at once; `in_tx` rises only after a begin from that context; the software hint rises only together with an abort; and forwarding happens only on a completed load. Only the bench's scenarios can show which snoops and local accesses count as conflicts, that discarded data never reaches the write-back port, the drain order and contents after a commit, the capacity abort with a full table and the recovery of slots afterwards, and the exact abort count at which the hint appears and the commit that clears it.

// File: rtl/htm_pkg.sv
package htm_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_BEGIN  = 3'd1,
        OP_COMMIT = 3'd2,
        OP_ABORT  = 3'd3,
        OP_LOAD   = 3'd4,
        OP_STORE  = 3'd5
    } htm_op_e;
endpackage

// File: rtl/htm_lowest.sv
// Lowest-index set bit finder.
module htm_lowest #(
    parameter int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/htm_line_match.sv
// Compares every live, uncommitted slot with the request and snoop addresses.
module htm_line_match #(
    parameter int NLINES = 4,
    parameter int AW     = 8
) (
    input  logic [NLINES-1:0]         slot_live,
    input  logic [NLINES-1:0][AW-1:0] slot_addr,
    input  logic [AW-1:0]             req_addr,
    input  logic [AW-1:0]             snp_addr,
    output logic [NLINES-1:0]         req_hit,
    output logic [NLINES-1:0]         snp_hit
);
    for (genvar g = 0; g < NLINES; g++) begin : g_cmp
        assign req_hit[g] = slot_live[g] && (slot_addr[g] == req_addr);
        assign snp_hit[g] = slot_live[g] && (slot_addr[g] == snp_addr);
    end
endmodule

// File: rtl/htm_conflict_tracker.sv
module htm_conflict_tracker
    import htm_pkg::*;
#(
    parameter int NCTX        = 2,
    parameter int NLINES      = 4,
    parameter int AW          = 8,
    parameter int DW          = 8,
    parameter int RETRY_LIMIT = 3,
    localparam int CW = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int IW = $clog2(NLINES),
    localparam int RW = $clog2(RETRY_LIMIT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic [CW-1:0]   req_ctx,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [NCTX-1:0] trap_ack,
    input  logic            snp_valid,
    input  logic            snp_write,
    input  logic [AW-1:0]   snp_addr,
    output logic [NCTX-1:0] in_tx,
    output logic [NCTX-1:0] doomed,
    output logic [NCTX-1:0] trap,
    output logic [NCTX-1:0] sw_hint,
    output logic            ld_valid,
    output logic            ld_fwd,
    output logic [DW-1:0]   ld_data,
    output logic            wb_valid,
    output logic [AW-1:0]   wb_addr,
    output logic [DW-1:0]   wb_data
);
    typedef struct packed {
        logic          used;
        logic          done;   // committed, waiting to drain
        logic [CW-1:0] owner;
        logic [AW-1:0] addr;
        logic          rd;
        logic          wr;
        logic [DW-1:0] data;
    } slot_t;

    typedef struct packed {
        slot_t [NLINES-1:0]           slot;
        logic  [NCTX-1:0]             act;
        logic  [NCTX-1:0]             exc;
        logic  [NCTX-1:0]             trp;
        logic  [NCTX-1:0][RW-1:0]     fails;
        logic                         ld_v;
        logic                         ld_f;
        logic  [DW-1:0]               ld_d;
        logic                         wb_v;
        logic  [AW-1:0]               wb_a;
        logic  [DW-1:0]               wb_d;
    } state_t;

    state_t state_d, state_q;

    logic [NLINES-1:0]         slot_live, slot_free, slot_drain;
    logic [NLINES-1:0][AW-1:0] slot_addr;
    logic [NLINES-1:0]         req_hit, snp_hit;
    logic                      free_found, drain_found;
    logic [IW-1:0]             free_idx, drain_idx;

    always_comb begin
        for (int i = 0; i < NLINES; i++) begin
            slot_live[i]  = state_q.slot[i].used && !state_q.slot[i].done;
            slot_free[i]  = !state_q.slot[i].used;
            slot_drain[i] = state_q.slot[i].used && state_q.slot[i].done;
            slot_addr[i]  = state_q.slot[i].addr;
        end
    end

    htm_line_match #(.NLINES(NLINES), .AW(AW)) u_match (
        .slot_live (slot_live),
        .slot_addr (slot_addr),
        .req_addr  (req_addr),
        .snp_addr  (snp_addr),
        .req_hit   (req_hit),
        .snp_hit   (snp_hit)
    );

    htm_lowest #(.N(NLINES)) u_free_pick (
        .req   (slot_free),
        .found (free_found),
        .idx   (free_idx)
    );

    htm_lowest #(.N(NLINES)) u_drain_pick (
        .req   (slot_drain),
        .found (drain_found),
        .idx   (drain_idx)
    );

    logic [NCTX-1:0] kill;
    logic            own_hit;
    logic [IW-1:0]   own_idx;
    logic            is_store;
    slot_t           fresh;

    always_comb begin
        state_d       = state_q;
        state_d.ld_v  = 1'b0;
        state_d.ld_f  = 1'b0;
        state_d.ld_d  = '0;
        state_d.wb_v  = 1'b0;
        kill          = '0;
        is_store      = (htm_op_e'(req_op) == OP_STORE);

        // own slot for the requesting context
        own_hit = 1'b0;
        own_idx = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (req_hit[i] && state_q.slot[i].owner == req_ctx) begin
                own_hit = 1'b1;
                own_idx = IW'(i);
            end
        end

        fresh       = '0;
        fresh.used  = 1'b1;
        fresh.owner = req_ctx;
        fresh.addr  = req_addr;
        fresh.rd    = !is_store;
        fresh.wr    = is_store;
        fresh.data  = is_store ? req_wdata : '0;

        // drain one committed line per cycle
        if (drain_found) begin
            state_d.wb_v                 = 1'b1;
            state_d.wb_a                 = state_q.slot[drain_idx].addr;
            state_d.wb_d                 = state_q.slot[drain_idx].data;
            state_d.slot[drain_idx].used = 1'b0;
            state_d.slot[drain_idx].done = 1'b0;
        end

        // remote snoops
        if (snp_valid) begin
            for (int i = 0; i < NLINES; i++) begin
                if (snp_hit[i] && (snp_write || state_q.slot[i].wr))
                    kill[state_q.slot[i].owner] = 1'b1;
            end
        end

        // core request
        if (req_valid && !kill[req_ctx]) begin
            if (state_q.exc[req_ctx]) begin
                if (htm_op_e'(req_op) inside {OP_COMMIT, OP_LOAD, OP_STORE})
                    state_d.trp[req_ctx] = 1'b1;
            end else if (!state_q.act[req_ctx]) begin
                if (htm_op_e'(req_op) == OP_BEGIN)
                    state_d.act[req_ctx] = 1'b1;
            end else begin
                unique case (htm_op_e'(req_op))
                    OP_COMMIT: begin
                        for (int i = 0; i < NLINES; i++) begin
                            if (slot_live[i] && state_q.slot[i].owner == req_ctx) begin
                                if (state_q.slot[i].wr) state_d.slot[i].done = 1'b1;
                                else                    state_d.slot[i].used = 1'b0;
                            end
                        end
                        state_d.act[req_ctx]   = 1'b0;
                        state_d.fails[req_ctx] = '0;
                    end
                    OP_ABORT: kill[req_ctx] = 1'b1;
                    OP_LOAD, OP_STORE: begin
                        for (int i = 0; i < NLINES; i++) begin
                            if (req_hit[i] && state_q.slot[i].owner != req_ctx &&
                                (is_store || state_q.slot[i].wr))
                                kill[state_q.slot[i].owner] = 1'b1;
                        end
                        if (own_hit) begin
                            if (is_store) begin
                                state_d.slot[own_idx].wr   = 1'b1;
                                state_d.slot[own_idx].data = req_wdata;
                            end else begin
                                state_d.slot[own_idx].rd   = 1'b1;
                            end
                        end else if (free_found) begin
                            state_d.slot[free_idx] = fresh;
                        end else begin
                            kill[req_ctx] = 1'b1;   // capacity
                        end
                        if (!is_store && (own_hit || free_found)) begin
                            state_d.ld_v = 1'b1;
                            state_d.ld_f = own_hit && state_q.slot[own_idx].wr;
                            state_d.ld_d = state_d.ld_f ? state_q.slot[own_idx].data : '0;
                        end
                    end
                    default: ;
                endcase
            end
        end

        // trap acknowledgment
        for (int k = 0; k < NCTX; k++) begin
            if (trap_ack[k]) begin
                state_d.trp[k] = 1'b0;
                state_d.exc[k] = 1'b0;
            end
        end

        // apply aborts
        for (int k = 0; k < NCTX; k++) begin
            if (kill[k] && state_q.act[k] && !state_q.exc[k]) begin
                state_d.act[k] = 1'b0;
                state_d.exc[k] = 1'b1;
                if (state_q.fails[k] != RW'(RETRY_LIMIT))
                    state_d.fails[k] = state_q.fails[k] + RW'(1);
                for (int i = 0; i < NLINES; i++) begin
                    if (state_d.slot[i].used && !state_d.slot[i].done &&
                        state_d.slot[i].owner == CW'(k))
                        state_d.slot[i].used = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        for (int k = 0; k < NCTX; k++)
            sw_hint[k] = (state_q.fails[k] == RW'(RETRY_LIMIT));
    end

    assign in_tx    = state_q.act;
    assign doomed   = state_q.exc;
    assign trap     = state_q.trp;
    assign ld_valid = state_q.ld_v;
    assign ld_fwd   = state_q.ld_f;
    assign ld_data  = state_q.ld_d;
    assign wb_valid = state_q.wb_v;
    assign wb_addr  = state_q.wb_a;
    assign wb_data  = state_q.wb_d;
endmodule

// File: rtl/htm_conflict_tracker_chk.sv
module htm_conflict_tracker_chk
    import htm_pkg::*;
#(
    parameter int NCTX = 2,
    localparam int CW = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [2:0]      req_op,
    input logic [CW-1:0]   req_ctx,
    input logic [NCTX-1:0] trap_ack,
    input logic [NCTX-1:0] in_tx,
    input logic [NCTX-1:0] doomed,
    input logic [NCTX-1:0] trap,
    input logic [NCTX-1:0] sw_hint,
    input logic            ld_valid,
    input logic            ld_fwd
);
    for (genvar g = 0; g < NCTX; g++) begin : g_ctx
        // R9: trap holds until acknowledged
        assert_trap_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
            trap[g] && !trap_ack[g] |=> trap[g]);
        // R9: a trap only rises for a doomed context
        assert_trap_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(trap[g]) |-> $past(doomed[g]));
        // R8: aborted context is no longer active
        assert_not_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(in_tx[g] && doomed[g]));
        // R2: activity only starts after a begin from this context
        assert_begin_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(in_tx[g]) |-> $past(req_valid && req_op == OP_BEGIN && req_ctx == CW'(g)));
        // R11: hint appears only together with an abort
        assert_hint_on_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sw_hint[g]) |-> $rose(doomed[g]));
    end

    // R3: forwarding only accompanies a completed load
    assert_fwd_needs_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fwd |-> ld_valid);
endmodule

bind htm_conflict_tracker htm_conflict_tracker_chk #(.NCTX(NCTX)) u_chk (.*);

// File: tb/htm_conflict_tracker_test.sv
`timescale 1ns/1ps
module htm_conflict_tracker_test;
    localparam int NCTX = 2, NLINES = 4, AW = 8, DW = 8, LIMIT = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [2:0]      req_op = '0;
    logic [0:0]      req_ctx = '0;
    logic [AW-1:0]   req_addr = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic [NCTX-1:0] trap_ack = '0;
    logic            snp_valid = 1'b0, snp_write = 1'b0;
    logic [AW-1:0]   snp_addr = '0;
    logic [NCTX-1:0] in_tx, doomed, trap, sw_hint;
    logic            ld_valid, ld_fwd, wb_valid;
    logic [DW-1:0]   ld_data, wb_data;
    logic [AW-1:0]   wb_addr;

    int vectors = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    htm_conflict_tracker #(.NCTX(NCTX), .NLINES(NLINES), .AW(AW), .DW(DW),
                           .RETRY_LIMIT(LIMIT)) uut (.*);

    localparam logic [2:0] BEG = 3'd1, CMT = 3'd2, ABT = 3'd3, LD = 3'd4, ST = 3'd5;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [2:0] o, input int c, input logic [7:0] a, input logic [7:0] w);
        req_valid = 1; req_op = o; req_ctx = 1'(c); req_addr = a; req_wdata = w;
        @(negedge clk);
        req_valid = 0; req_op = '0;
    endtask

    task automatic snoop(input logic wr, input logic [7:0] a);
        snp_valid = 1; snp_write = wr; snp_addr = a;
        @(negedge clk);
        snp_valid = 0;
    endtask

    task automatic ack(input int c);
        trap_ack[c] = 1'b1;
        @(negedge clk);
        trap_ack = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vectors++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 in_tx", in_tx, 0);
        chk("R1 doomed", doomed, 0);
        chk("R1 trap", trap, 0);
        chk("R1 hint", sw_hint, 0);
        chk("R1 wb_valid", wb_valid, 0);
        chk("R1 ld_valid", ld_valid, 0);

        // R2 begin
        op(BEG, 0, 0, 0);
        chk("R2 begin ctx0", in_tx, 2'b01);

        // R3 tracked accesses and forwarding
        op(ST, 0, 8'h10, 8'hA1);
        op(ST, 0, 8'h11, 8'hB2);
        op(LD, 0, 8'h12, 0);
        chk("R3 load valid", ld_valid, 1);
        chk("R3 read-only no fwd", ld_fwd, 0);
        op(LD, 0, 8'h10, 0);
        chk("R3 fwd flag", ld_fwd, 1);
        chk("R3 fwd data", ld_data, 8'hA1);
        op(ST, 0, 8'h11, 8'hC3);   // overwrite own line
        chk("R4 no wb before commit", wb_valid, 0);

        // R5/R6 non-conflicting snoops
        snoop(0, 8'h12);
        chk("R6 read snoop on read line", in_tx, 2'b01);
        snoop(1, 8'h99);
        chk("R5 write snoop miss", in_tx, 2'b01);
        chk("R5 write snoop miss doomed", doomed, 0);

        // R4 commit and drain
        op(CMT, 0, 0, 0);
        chk("R4 commit ends tx", in_tx, 0);
        chk("R4 no wb in commit cycle", wb_valid, 0);
        idle(1);
        chk("R4 drain 1 valid", wb_valid, 1);
        chk("R4 drain 1 addr", wb_addr, 8'h10);
        chk("R4 drain 1 data", wb_data, 8'hA1);
        idle(1);
        chk("R4 drain 2 addr", wb_addr, 8'h11);
        chk("R4 drain 2 data", wb_data, 8'hC3);
        idle(1);
        chk("R4 read-only not drained", wb_valid, 0);

        // R5 write snoop conflicts on read and on written line, R8, R9
        for (int v = 0; v < 2; v++) begin
            op(BEG, 1, 0, 0);
            op(v == 0 ? LD : ST, 1, 8'h20, 8'h55);
            snoop(1, 8'h20);
            chk("R5 write snoop aborts", doomed, 2'b10);
            chk("R8 in_tx falls", in_tx, 0);
            op(CMT, 1, 0, 0);
            chk("R9 commit traps", trap, 2'b10);
            idle(1);
            chk("R9 trap held", trap, 2'b10);
            chk("R8 discarded data not drained", wb_valid, 0);
            ack(1);
            chk("R9 ack clears trap", trap, 0);
            chk("R9 ack clears doomed", doomed, 0);
            chk("R11 hint below limit", sw_hint, 0);
        end

        // R6 read snoop on written line; third abort sets hint (R11)
        op(BEG, 1, 0, 0);
        op(ST, 1, 8'h30, 8'h77);
        snoop(0, 8'h30);
        chk("R6 read snoop on written line", doomed, 2'b10);
        chk("R11 hint at limit", sw_hint, 2'b10);
        ack(1);
        op(BEG, 1, 0, 0);
        op(LD, 1, 8'h31, 0);
        op(CMT, 1, 0, 0);
        chk("R11 commit clears hint", sw_hint, 0);

        // R7 local single writer
        op(BEG, 0, 0, 0);
        op(BEG, 1, 0, 0);
        op(LD, 0, 8'h40, 0);
        op(ST, 1, 8'h40, 8'h9E);
        chk("R7 store aborts other reader", doomed, 2'b01);
        chk("R7 writer continues", in_tx, 2'b10);
        ack(0);
        op(BEG, 0, 0, 0);
        op(LD, 0, 8'h40, 0);
        chk("R7 load of foreign written line aborts", doomed, 2'b10);
        chk("R7 loader continues", in_tx, 2'b01);
        chk("R7 no fwd of foreign data", ld_fwd, 0);
        ack(1);
        op(CMT, 0, 0, 0);
        idle(3);

        // R10 capacity sweep
        op(BEG, 0, 0, 0);
        for (int k = 0; k <= NLINES; k++) begin
            op(ST, 0, 8'(8'h50 + k), 8'(8'hE0 + k));
            chk("R10 capacity", doomed[0], (k == NLINES) ? 1 : 0);
        end
        ack(0);

        // R8 slots recovered after abort
        op(BEG, 0, 0, 0);
        for (int k = 0; k < NLINES; k++) op(ST, 0, 8'(8'h60 + k), 8'(8'h70 + k));
        chk("R8 slots recovered", in_tx[0], 1);
        op(CMT, 0, 0, 0);
        for (int k = 0; k < NLINES; k++) begin
            idle(1);
            chk("R4 drain order addr", wb_addr, 8'h60 + k);
            chk("R4 drain order data", wb_data, 8'h70 + k);
        end
        idle(1);
        chk("R4 drain finished", wb_valid, 0);

        // R2 begin while doomed ignored; R9 load while doomed traps
        op(BEG, 1, 0, 0);
        op(ABT, 1, 0, 0);
        chk("R11 explicit abort dooms", doomed, 2'b10);
        op(BEG, 1, 0, 0);
        chk("R2 begin while doomed ignored", in_tx, 0);
        chk("R2 begin while doomed no trap", trap, 0);
        op(LD, 1, 8'h80, 0);
        chk("R9 load while doomed traps", trap, 2'b10);
        chk("R9 trapped load not completed", ld_valid, 0);
        ack(1);

        // R11 retry sweep from a clean count
        op(BEG, 1, 0, 0);
        op(CMT, 1, 0, 0);
        for (int n = 1; n <= LIMIT + 1; n++) begin
            op(BEG, 1, 0, 0);
            op(ABT, 1, 0, 0);
            chk("R11 hint vs abort count", sw_hint[1], (n >= LIMIT) ? 1 : 0);
            chk("R11 other ctx unaffected", sw_hint[0], 0);
            ack(1);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule